// File: doc/BRIEF.md
# PWM Ramp Edge-Time Generator

This block works out where the two switching edges of one PWM ramp fall and runs the ramp counter that those edges are compared against. A 10-bit duty word sets the on-time as a fraction of the effective period. The duty comes either from the control loop or from a forced register value. The modulation mode then decides which edge stays fixed and which edge moves with the duty. Each edge time can also be overridden on its own by a forced value that has its own enable. One count of the counter, and one LSB of an edge time, stands for 5 ns.

The counter runs from 0 up to period − 1 and then wraps. The edge pair is captured only when the counter wraps, so a change to any input takes effect at the start of the next ramp cycle. The raw PWM level is high while the counter lies between the two edges. Dead-time insertion, the loop compensator and register decoding live outside this block.

Top module: `pwm_edge_gen`

## Requirements
- R1: Edge times and the period are 11-bit counts of 5 ns. The ramp count advances by one each clock from 0 to period − 1 and then returns to 0. With a period of 0 or 1 the count stays at 0.
- R2: When `duty_force_en` is 0 the duty in use is `loop_duty`. When it is 1 the duty in use is `duty_force`.
- R3: The effective period is `period`, or `period` shifted right by one when `bridge` is 1. The on-time is floor(duty × effective period / 1024).
- R4: Trailing mode (`mode` = 0, and the unused code 3 behaves the same) gives t1 = 0 and t2 = on-time.
- R5: Leading mode (`mode` = 1) gives t1 = effective period − on-time and t2 = effective period.
- R6: Dual-edge mode (`mode` = 2) centres the pulse: t1 = floor((effective period − on-time)/2) and t2 = t1 + on-time.
- R7: When `t1_force_en` is 1, t1 takes `t1_force` in place of the mode result. `t2_force_en` with `t2_force` does the same for t2, independently of t1.
- R8: Any edge value above `period` is clamped to `period`.
- R9: New t1/t2 values are captured on the clock edge that returns the count to 0, using the inputs present at that edge. At every other edge they hold.
- R10: `cycle_start` is high exactly while the count is 0. `pwm_raw` is high exactly while t1 ≤ count < t2.
- R11: A synchronous reset sets the count to 0 and t1 = t2 = 0. The first ramp cycle after reset therefore keeps `pwm_raw` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per 5 ns count |
| rst | input | 1 | Synchronous active-high reset |
| loop_duty | input | 10 | Duty from the control loop, fraction of 1024 |
| duty_force_en | input | 1 | Selects the forced duty |
| duty_force | input | 10 | Forced duty value |
| mode | input | 2 | 0 trailing, 1 leading, 2 dual edge, 3 as trailing |
| period | input | 11 | Switching period in counts |
| bridge | input | 1 | Halves the effective period |
| t1_force_en | input | 1 | Override enable for t1 |
| t1_force | input | 11 | Forced t1 value |
| t2_force_en | input | 1 | Override enable for t2 |
| t2_force | input | 11 | Forced t2 value |
| t1 | output | 11 | First edge time in use |
| t2 | output | 11 | Second edge time in use |
| cycle_start | output | 1 | High while the count is 0 |
| pwm_raw | output | 1 | Raw PWM level |

## Verification
Outputs `t1` and `t2` change only on the clock edge that brings the count back to 0. That edge is one register stage after the inputs that feed it, and no output has a combinational path from an input. `cycle_start` and `pwm_raw` follow the count and the captured edges within the same cycle. A behavioural model in the bench advances on every rising edge and is compared with all four outputs at each falling edge. The directed edge-value checks are taken only after at least two full ramp periods, so a capture has certainly happened.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

    localparam int EDGE_W = 11;
    localparam int DUTY_W = 10;

    typedef enum logic [1:0] {
        MOD_TRAIL = 2'd0,
        MOD_LEAD  = 2'd1,
        MOD_DUAL  = 2'd2,
        MOD_RSVD  = 2'd3
    } mod_e;

endpackage

// File: rtl/pwm_edge_calc.sv
module pwm_edge_calc
    import pwm_edge_pkg::*;
#(
    parameter int EW = EDGE_W,
    parameter int DW = DUTY_W
) (
    input  logic [DW-1:0] loop_duty,
    input  logic          duty_sel,
    input  logic [DW-1:0] duty_ovr,
    input  mod_e          mode,
    input  logic [EW-1:0] period,
    input  logic          bridge,
    input  logic          t1_ovr_en,
    input  logic [EW-1:0] t1_ovr,
    input  logic          t2_ovr_en,
    input  logic [EW-1:0] t2_ovr,
    output logic [EW-1:0] t1_next,
    output logic [EW-1:0] t2_next
);

    localparam int PW = EW + DW;

    logic [DW-1:0] duty;
    logic [EW-1:0] pe;
    logic [PW-1:0] prod;
    logic [EW-1:0] on_t;
    logic [EW-1:0] gap;
    logic [EW-1:0] t1_m, t2_m;
    logic [EW-1:0] t1_f, t2_f;

    always_comb begin
        duty = duty_sel ? duty_ovr : loop_duty;
        pe   = bridge ? (period >> 1) : period;
        prod = {{DW{1'b0}}, pe} * {{EW{1'b0}}, duty};
        on_t = prod[PW-1:DW];
        gap  = pe - on_t;
        unique case (mode)
            MOD_LEAD: begin
                t1_m = gap;
                t2_m = pe;
            end
            MOD_DUAL: begin
                t1_m = gap >> 1;
                t2_m = (gap >> 1) + on_t;
            end
            default: begin
                t1_m = '0;
                t2_m = on_t;
            end
        endcase
        t1_f    = t1_ovr_en ? t1_ovr : t1_m;
        t2_f    = t2_ovr_en ? t2_ovr : t2_m;
        t1_next = (t1_f > period) ? period : t1_f;
        t2_next = (t2_f > period) ? period : t2_f;
    end

    // R4: trailing mode without override leaves the first edge at zero
    always_comb begin
        if (mode == MOD_TRAIL && !t1_ovr_en)
            assert_trail_rise_zero_R4: assert (t1_next == '0);
    end

    // R8: a result never lands past the period
    always_comb begin
        assert_edge_in_period_R8: assert (t1_next <= period && t2_next <= period);
    end

endmodule

// File: rtl/pwm_ramp_ctr.sv
module pwm_ramp_ctr
    import pwm_edge_pkg::*;
#(
    parameter int EW = EDGE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [EW-1:0] period,
    output logic [EW-1:0] cnt,
    output logic          wrap
);

    logic [EW:0] cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt} + (EW+1)'(1);
        wrap    = (cnt_inc >= {1'b0, period});
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt_inc[EW-1:0];
    end

    // R1: the count either restarts or steps by exactly one
    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt == '0 || cnt == $past(cnt) + EW'(1)));

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
    import pwm_edge_pkg::*;
#(
    parameter int EW = EDGE_W,
    parameter int DW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] loop_duty,
    input  logic          duty_force_en,
    input  logic [DW-1:0] duty_force,
    input  logic [1:0]    mode,
    input  logic [EW-1:0] period,
    input  logic          bridge,
    input  logic          t1_force_en,
    input  logic [EW-1:0] t1_force,
    input  logic          t2_force_en,
    input  logic [EW-1:0] t2_force,
    output logic [EW-1:0] t1,
    output logic [EW-1:0] t2,
    output logic          cycle_start,
    output logic          pwm_raw
);

    logic [EW-1:0] t1_calc, t2_calc;
    logic [EW-1:0] t1_q, t2_q;
    logic [EW-1:0] cnt;
    logic          wrap;

    pwm_edge_calc #(.EW(EW), .DW(DW)) u_calc (
        .loop_duty (loop_duty),
        .duty_sel  (duty_force_en),
        .duty_ovr  (duty_force),
        .mode      (mod_e'(mode)),
        .period    (period),
        .bridge    (bridge),
        .t1_ovr_en (t1_force_en),
        .t1_ovr    (t1_force),
        .t2_ovr_en (t2_force_en),
        .t2_ovr    (t2_force),
        .t1_next   (t1_calc),
        .t2_next   (t2_calc)
    );

    pwm_ramp_ctr #(.EW(EW)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .period (period),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_q <= '0;
            t2_q <= '0;
        end else if (wrap) begin
            t1_q <= t1_calc;
            t2_q <= t2_calc;
        end
    end

    always_comb begin
        t1          = t1_q;
        t2          = t2_q;
        cycle_start = (cnt == '0);
        pwm_raw     = (cnt >= t1_q) && (cnt < t2_q);
    end

    // R9: captured edges hold between wraps
    assert_edges_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(t1_q) && $stable(t2_q)));

    // R8: captured edges respect the period seen at capture
    assert_capture_clamped_R8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (t1_q <= $past(period) && t2_q <= $past(period)));

    // R10: a wrap is followed by a cycle-start cycle
    assert_start_after_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cycle_start);

endmodule

// File: tb/pwm_edge_gen_test.sv
module pwm_edge_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  loop_duty = '0;
    logic        duty_force_en = 1'b0;
    logic [9:0]  duty_force = '0;
    logic [1:0]  mode = 2'd0;
    logic [10:0] period = 11'd20;
    logic        bridge = 1'b0;
    logic        t1_force_en = 1'b0;
    logic [10:0] t1_force = '0;
    logic        t2_force_en = 1'b0;
    logic [10:0] t2_force = '0;
    logic [10:0] t1, t2;
    logic        cycle_start, pwm_raw;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0, m_t1 = 0, m_t2 = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    pwm_edge_gen uut (
        .clk(clk), .rst(rst),
        .loop_duty(loop_duty), .duty_force_en(duty_force_en), .duty_force(duty_force),
        .mode(mode), .period(period), .bridge(bridge),
        .t1_force_en(t1_force_en), .t1_force(t1_force),
        .t2_force_en(t2_force_en), .t2_force(t2_force),
        .t1(t1), .t2(t2), .cycle_start(cycle_start), .pwm_raw(pwm_raw)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural edge computation straight from the requirements
    task automatic ref_edges(output int a, output int b);
        int d, pe, on, p;
        p  = int'(period);
        d  = duty_force_en ? int'(duty_force) : int'(loop_duty);
        pe = bridge ? p / 2 : p;
        on = (d * pe) / 1024;
        case (mode)
            2'd1: begin a = pe - on; b = pe; end
            2'd2: begin a = (pe - on) / 2; b = a + on; end
            default: begin a = 0; b = on; end
        endcase
        if (t1_force_en) a = int'(t1_force);
        if (t2_force_en) b = int'(t2_force);
        if (a > p) a = p;
        if (b > p) b = p;
    endtask

    always @(posedge clk) begin
        int na, nb;
        if (rst) begin
            m_cnt = 0; m_t1 = 0; m_t2 = 0;
        end else if (m_cnt + 1 >= int'(period)) begin
            ref_edges(na, nb);
            m_t1 = na; m_t2 = nb; m_cnt = 0;
        end else begin
            m_cnt++;
        end
    end

    // per-cycle comparison at the falling edge (R9, R10)
    always @(negedge clk) begin
        if (model_on) begin
            chk("R9 t1 model", int'(t1), m_t1);
            chk("R9 t2 model", int'(t2), m_t2);
            chk("R10 cycle_start model", int'(cycle_start), int'(m_cnt == 0));
            chk("R10 pwm_raw model", int'(pwm_raw), int'(m_t1 <= m_cnt && m_cnt < m_t2));
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        run(2 * int'(period) + 3);
    endtask

    initial begin
        int hi;
        run(3);
        chk("R11 reset t1", int'(t1), 0);
        chk("R11 reset t2", int'(t2), 0);
        chk("R11 reset pwm_raw", int'(pwm_raw), 0);
        rst = 1'b0;
        model_on = 1'b1;

        // R1: count period - checked via cycle_start spacing
        loop_duty = 10'd512;
        run(1);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (cycle_start) hi++;
            run(1);
        end
        chk("R1 one start per 20 counts", hi, 1);
        chk("R11 first cycle idle t2", int'(t2) <= 10 ? 1 : 0, 1);

        settle();
        chk("R4 trailing t1", int'(t1), 0);
        chk("R4 trailing t2", int'(t2), 10);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (pwm_raw) hi++;
            run(1);
        end
        chk("R10 high count trailing", hi, 10);

        mode = 2'd1; settle();
        chk("R5 leading t1", int'(t1), 10);
        chk("R5 leading t2", int'(t2), 20);

        mode = 2'd2; loop_duty = 10'd300; settle();
        chk("R6 dual t1", int'(t1), 7);
        chk("R6 dual t2", int'(t2), 12);

        mode = 2'd3; settle();
        chk("R4 code3 t1", int'(t1), 0);
        chk("R4 code3 t2", int'(t2), 5);

        mode = 2'd1; period = 11'd40; bridge = 1'b1; loop_duty = 10'd512; settle();
        chk("R3 bridge lead t1", int'(t1), 10);
        chk("R3 bridge lead t2", int'(t2), 20);

        bridge = 1'b0; period = 11'd20; mode = 2'd0; loop_duty = 10'd0;
        duty_force_en = 1'b1; duty_force = 10'd1023; settle();
        chk("R2 forced duty t2", int'(t2), 19);
        duty_force_en = 1'b0; settle();
        chk("R2 loop duty t2", int'(t2), 0);

        loop_duty = 10'd512; t1_force_en = 1'b1; t1_force = 11'd3; settle();
        chk("R7 t1 forced", int'(t1), 3);
        chk("R7 t2 untouched", int'(t2), 10);
        t1_force_en = 1'b0; t2_force_en = 1'b1; t2_force = 11'd2000; settle();
        chk("R7 t1 back to mode", int'(t1), 0);
        chk("R8 t2 clamped", int'(t2), 20);
        t2_force_en = 1'b0;

        // R9: mid-cycle change must not move the edges until the wrap
        settle();
        run(5);
        loop_duty = 10'd256;
        run(3);
        chk("R9 hold mid-cycle t2", int'(t2), 10);
        settle();
        chk("R9 after wrap t2", int'(t2), 5);

        period = 11'd2047; loop_duty = 10'd1023; settle();
        chk("R3 max period t2", int'(t2), 2045);

        period = 11'd1; run(10);
        chk("R1 period one start", int'(cycle_start), 1);

        model_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule